// File: doc/BRIEF.md
# Receive Byte Counter with Early Warning

This block sits in a network receive path beside the frame deserializer. It counts the bytes of the frame being received and restarts from zero when each new reception begins. When a frame ends it flags a frame that is too short so that the frame can be dropped. The flag is suppressed when the accept-short configuration bit is set.

The block also raises an early warning as soon as the live byte count reaches a programmable threshold. Software can then start moving data before the frame is complete. The threshold is an 8-bit value counted in 16-byte units. The warning is a sticky status bit, and a mask bit gates it onto an interrupt line. After software clears the warning it stays clear until a new frame starts or the threshold is rewritten. Writing a threshold at or below the live count during a reception raises the warning in that same cycle.

Top module: `rx_bytecount_warn`

## Requirements
- R1: After reset `byte_count`, `runt_reject`, `int_status` and `irq` are all zero, and the stored threshold is 255.
- R2: On the cycle where `rx_active` rises, the count restarts from zero. Each cycle with `rx_active` and `byte_vld` both high adds one to the count at the next clock edge, and this includes a byte on the rising cycle itself. Outside a reception the count holds its last value.
- R3: The 13-bit count saturates at 8191 and never wraps.
- R4: One cycle after a `frame_end` pulse, `runt_reject` is high for one cycle if the count is below 64 and `accept_runt` is low. The count used here includes any byte in the `frame_end` cycle. Otherwise `runt_reject` stays low.
- R5: The warning is set on the clock edge at which the count becomes equal to or greater than threshold×16. A threshold of 0 sets the warning on the first cycle of a reception.
- R6: The warning is never set by a clock edge whose cycle has `rx_active` low, and this holds even when a threshold is written.
- R7: Once the warning has fired and has then been cleared with `warn_clr`, it stays clear for the rest of that frame. Only a new frame start or a threshold write can make it fire again.
- R8: A threshold write (`thr_we`) during a reception with a value whose ×16 is at or below the live count sets the warning on the edge of that write.
- R9: The warning is bit 6 of `int_status`, and all other bits of `int_status` read 0. `irq` equals bit 6 ANDed with `warn_mask`.
- R10: If `warn_clr` and a set condition occur in the same cycle, the warning ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One received byte this cycle |
| rx_active | input | 1 | Reception in progress; a rising edge starts a frame |
| frame_end | input | 1 | End-of-frame pulse |
| accept_runt | input | 1 | When high, short frames are not rejected |
| thr_wdata | input | 8 | Threshold value in 16-byte units |
| thr_we | input | 1 | Threshold write strobe |
| warn_clr | input | 1 | Clears the warning status |
| warn_mask | input | 1 | Interrupt enable for the warning |
| byte_count | output | 13 | Live byte count of the current or last frame |
| runt_reject | output | 1 | Short-frame reject pulse |
| int_status | output | 8 | Interrupt status word, warning in bit 6 |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can fall in the same cycle: software clearing the warning, and the warning firing, either from a threshold write or from the count crossing the threshold. The bench holds a reception open with no bytes arriving. In that state it pulses `warn_clr` together with a threshold write at or below the live count, and it expects the status bit to read 1 on the next sample. A separate clear without a write must leave the bit at 0. The same pairing is also provoked with the byte stream running. In that case the clear lands on the exact cycle the count reaches the threshold, and the bit must again survive the clear.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;
    localparam int WARN_BIT_POS = 6;

    // Saturating increment of an unsigned count of width w (w <= 32).
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input int w);
        logic [31:0] lim;
        lim = (32'd1 << w) - 32'd1;
        return (v >= lim) ? lim : v + 32'd1;
    endfunction
endpackage

// File: rtl/rxbc_counter.sv
module rxbc_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             rx_active,
    output logic             start,
    output logic [CNT_W-1:0] count_nxt,
    output logic [CNT_W-1:0] count_cur
);
    import rxbc_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             active;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d        = st_q;
        st_d.active = rx_active;
        start       = rx_active & ~st_q.active;
        base        = start ? '0 : st_q.count;
        if (rx_active && byte_vld)
            st_d.count = CNT_W'(sat_inc(32'(base), CNT_W));
        else
            st_d.count = base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_nxt = st_d.count;
    assign count_cur = st_q.count;
endmodule

// File: rtl/rxbc_runt.sv
module rxbc_runt #(
    parameter int CNT_W   = 13,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             accept_runt,
    input  logic [CNT_W-1:0] count_nxt,
    output logic             runt_reject
);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

    typedef struct packed {
        logic reject;
    } runt_state_t;

    runt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.reject = frame_end && !accept_runt && (count_nxt < MIN_CNT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign runt_reject = st_q.reject;
endmodule

// File: rtl/rxbc_warn.sv
module rxbc_warn #(
    parameter int               CNT_W     = 13,
    parameter int               THR_W     = 8,
    parameter int               THR_SHIFT = 4,
    parameter logic [THR_W-1:0] THR_RST   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rx_active,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             warn_clr,
    output logic             warn,
    output logic [THR_W-1:0] thr_val
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             armed;
        logic             warn;
    } warn_state_t;

    warn_state_t      st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             armed_now;
    logic             fire;

    always_comb begin
        st_d      = st_q;
        st_d.thr  = thr_we ? thr_wdata : st_q.thr;
        limit     = CNT_W'(st_d.thr) << THR_SHIFT;
        armed_now = st_q.armed | start | thr_we;
        fire      = armed_now && rx_active && (count_nxt >= limit);
        st_d.armed = fire ? 1'b0 : armed_now;
        if (fire)          st_d.warn = 1'b1;
        else if (warn_clr) st_d.warn = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{thr: THR_RST, armed: 1'b0, warn: 1'b0};
        else        st_q <= st_d;
    end

    assign warn    = st_q.warn;
    assign thr_val = st_q.thr;
endmodule

// File: rtl/rx_bytecount_warn.sv
module rx_bytecount_warn #(
    parameter int CNT_W     = 13,
    parameter int THR_W     = 8,
    parameter int THR_SHIFT = 4,
    parameter int MIN_LEN   = 64,
    parameter int STAT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              rx_active,
    input  logic              frame_end,
    input  logic              accept_runt,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic              thr_we,
    input  logic              warn_clr,
    input  logic              warn_mask,
    output logic [CNT_W-1:0]  byte_count,
    output logic              runt_reject,
    output logic [STAT_W-1:0] int_status,
    output logic              irq
);
    import rxbc_pkg::*;

    logic             start;
    logic [CNT_W-1:0] count_nxt;
    logic             warn;
    logic [THR_W-1:0] thr_val;

    rxbc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_active(rx_active),
        .start(start), .count_nxt(count_nxt), .count_cur(byte_count)
    );

    rxbc_runt #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_runt (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .accept_runt(accept_runt),
        .count_nxt(count_nxt), .runt_reject(runt_reject)
    );

    rxbc_warn #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)) u_warn (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_active(rx_active),
        .count_nxt(count_nxt), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .warn_clr(warn_clr), .warn(warn), .thr_val(thr_val)
    );

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == WARN_BIT_POS) begin : g_warn
            assign int_status[b] = warn;
        end else begin : g_zero
            assign int_status[b] = 1'b0;
        end
    end

    assign irq = warn & warn_mask;
endmodule

// File: rtl/rxbc_checker.sv
module rxbc_checker #(
    parameter int CNT_W     = 13,
    parameter int THR_W     = 8,
    parameter int THR_SHIFT = 4,
    parameter int STAT_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_active,
    input logic              frame_end,
    input logic              accept_runt,
    input logic              warn_clr,
    input logic [CNT_W-1:0]  byte_count,
    input logic              runt_reject,
    input logic [STAT_W-1:0] int_status,
    input logic [THR_W-1:0]  thr_val
);
    localparam int WB = 6;

    p_restart_only_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count < $past(byte_count)) |-> ($past(rx_active) && !$past(rx_active, 2)));

    p_runt_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        runt_reject |-> ($past(frame_end) && !$past(accept_runt)));

    p_warn_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[WB]) |-> (byte_count >= (CNT_W'(thr_val) << THR_SHIFT)));

    p_warn_needs_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[WB]) |-> $past(rx_active));

    p_fall_by_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[WB]) |-> $past(warn_clr));
endmodule

bind rx_bytecount_warn rxbc_checker #(
    .CNT_W(CNT_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .frame_end(frame_end),
    .accept_runt(accept_runt), .warn_clr(warn_clr), .byte_count(byte_count),
    .runt_reject(runt_reject), .int_status(int_status), .thr_val(thr_val)
);

// File: tb/tb_rx_bytecount_warn.sv
module tb_rx_bytecount_warn;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 0, rx_active = 0, frame_end = 0, accept_runt = 0;
    logic [7:0]  thr_wdata = 0;
    logic        thr_we = 0, warn_clr = 0, warn_mask = 0;
    logic [12:0] byte_count;
    logic        runt_reject;
    logic [7:0]  int_status;
    logic        irq;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    rx_bytecount_warn dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_active(rx_active),
        .frame_end(frame_end), .accept_runt(accept_runt), .thr_wdata(thr_wdata),
        .thr_we(thr_we), .warn_clr(warn_clr), .warn_mask(warn_mask),
        .byte_count(byte_count), .runt_reject(runt_reject),
        .int_status(int_status), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs, pass one rising edge, land on the next falling edge.
    task automatic step(input logic bv, input logic act, input logic fe,
                        input logic clr, input logic we, input logic [7:0] wd);
        byte_vld = bv; rx_active = act; frame_end = fe;
        warn_clr = clr; thr_we = we; thr_wdata = wd;
        @(negedge clk);
        byte_vld = 0; frame_end = 0; warn_clr = 0; thr_we = 0;
    endtask

    task automatic clear_idle();
        step(0, 0, 0, 1, 0, 0);
        chk(int_status[6] == 0, "R7 clear", int_status[6], 0);
    endtask

    task automatic do_frame(input int len, input int thr, input logic acc);
        int  exp_cnt;
        logic exp_w;
        clear_idle();
        step(0, 0, 0, 0, 1, 8'(thr));
        chk(int_status[6] == 0, "R6 idle write", int_status[6], 0);
        accept_runt = acc;
        exp_w = 0;
        for (int i = 0; i <= len; i++) begin
            step(i > 0, 1, 0, 0, 0, 0);
            exp_cnt = (i > 8191) ? 8191 : i;
            if (exp_cnt >= thr * 16) exp_w = 1;
            chk(byte_count == 13'(exp_cnt), (i > 8191) ? "R3 sat" : "R2 count", byte_count, exp_cnt);
            chk(int_status[6] == exp_w, "R5 warn", int_status[6], exp_w);
        end
        step(0, 0, 1, 0, 0, 0);
        chk(runt_reject == ((len < 64) && !acc), "R4 runt", runt_reject, (len < 64) && !acc);
        chk(byte_count == 13'((len > 8191) ? 8191 : len), "R2 hold", byte_count, len);
        step(0, 0, 0, 0, 0, 0);
        chk(runt_reject == 0, "R4 pulse", runt_reject, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk(byte_count == 0, "R1 count", byte_count, 0);
        chk(int_status == 0, "R1 status", int_status, 0);
        chk(irq == 0 && runt_reject == 0, "R1 flags", {irq, runt_reject}, 0);
        rst_n = 1;
        @(negedge clk);
        // R1: reset threshold 255 -> a 100-byte frame gives no warning
        step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 100; i++) step(1, 1, 0, 0, 0, 0);
        chk(int_status[6] == 0, "R1 thr255", int_status[6], 0);
        step(0, 0, 1, 0, 0, 0);

        // R4 / R2 sweep of lengths with both accept settings
        for (int a = 0; a < 2; a++)
            for (int len = 0; len <= 70; len++)
                do_frame(len, 255, a[0]);
        // R5 threshold sweep
        for (int t = 0; t <= 6; t++) do_frame(110, t, 0);
        // R3 saturation
        do_frame(8195, 255, 0);

        // R7: fire, clear, stays clear; R8 write below live count; R10 set wins
        clear_idle();
        step(0, 0, 0, 0, 1, 8'd2);
        step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 0, 0);
        chk(int_status[6] == 1, "R5 fired", int_status[6], 1);
        step(0, 1, 0, 1, 0, 0);
        chk(int_status[6] == 0, "R7 cleared", int_status[6], 0);
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, 0);
        chk(int_status[6] == 0, "R7 stays clear", int_status[6], 0);
        step(0, 1, 0, 0, 1, 8'd1);
        chk(int_status[6] == 1, "R8 write below", int_status[6], 1);
        step(0, 1, 0, 1, 1, 8'd3);
        chk(int_status[6] == 1, "R10 set wins", int_status[6], 1);
        step(0, 1, 0, 1, 1, 8'd200);
        chk(int_status[6] == 0, "R8 write above", int_status[6], 0);
        // R9 mask and other bits
        step(0, 1, 0, 0, 1, 8'd0);
        warn_mask = 0; #1;
        chk(irq == 0, "R9 masked", irq, 0);
        warn_mask = 1; #1;
        chk(irq == 1, "R9 unmasked", irq, 1);
        chk(int_status == 8'h40, "R9 bit6", int_status, 8'h40);
        step(0, 0, 1, 1, 0, 0);
        chk(irq == 0, "R9 cleared irq", irq, 0);
        // R6: threshold write at/below stale count while idle does not fire
        step(0, 0, 0, 0, 1, 8'd0);
        chk(int_status[6] == 0, "R6 idle", int_status[6], 0);
        // R10 with byte stream: clear on the exact crossing cycle
        step(0, 0, 0, 0, 1, 8'd1);
        step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 15; i++) step(1, 1, 0, 0, 0, 0);
        chk(int_status[6] == 0, "R5 below", int_status[6], 0);
        step(1, 1, 0, 1, 0, 0);
        chk(int_status[6] == 1, "R10 crossing", int_status[6], 1);
        step(0, 0, 1, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule